// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block is the serial control port of a dual frequency synthesizer. Control words arrive one bit at a time on a serial data pin, clocked by a serial clock pin, and are committed by a separate load strobe pin. Each word is 24 bits and is sent most significant bit first. The two lowest bits of the word form an address. On a rising edge of the load strobe, the address picks one of four holding registers, and the whole word is copied into that register. The four registers drive the divider and control logic in parallel.

All three serial pins are asynchronous to the system clock. Each pin passes through a two-stage synchronizer. Rising edges are then found in the system clock domain. For this reason, the serial clock must stay high for at least two system clock periods and low for at least two system clock periods. Serial data must be stable around each rising serial clock edge. The parallel outputs are plain registered levels with no handshake. A register changes only when a load addresses it.

Top module: `triwire_load_port`

## Requirements
- R1: Each rising edge of `sclk_i` shifts the value of `sdata_i` into bit 0 of a 24-bit shift register, and the older bits move one place toward bit 23. As a result, the first bit sent of a 24-bit word ends up in bit 23 (most significant bit first).
- R2: If more than 24 bits are shifted in before a load, only the last 24 bits sent are kept.
- R3: Word bits [1:0] select the target register: 0 selects register 0, 1 selects register 1, 2 selects register 2, and 3 selects register 3. Register k occupies `regs_o[24*k +: 24]`.
- R4: A rising edge of `sload_i` copies the whole 24-bit shift register into the selected register. The copy includes the two address bits.
- R5: A load leaves the three registers it does not address unchanged.
- R6: While `rst_n` is low, all four registers and the shift register are zero.
- R7: Holding `sload_i` high causes one load only. Serial bits shifted while `sload_i` stays high do not reach any register until the next rising edge of `sload_i`.
- R8: After `sload_i` rises, the addressed register shows the new word from the third rising edge of `clk`. After only two edges it still holds its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| sdata_i | input | 1 | Serial data, most significant bit first (asynchronous) |
| sload_i | input | 1 | Load strobe; a rising edge commits the word (asynchronous) |
| regs_o | output | 96 | Four 24-bit holding registers, register k at bits [24*k +: 24] |

## Verification
The assertions check on every cycle that each detected serial clock edge shifts exactly one bit into the low end of the shift register, and that the register holds its value otherwise. They also check that the internal load pulse lasts one cycle, that at most one register is written per load, that the written register receives the word, and that every register not written keeps its value. Only the bench scenarios can show the behaviour seen from outside the block. These scenarios cover the address decode seen at the pins, the loss of extra leading bits, the single load while the strobe is held high, the cleared state during reset, and the exact cycle in which a register changes after the strobe rises.

// File: rtl/tlp_pkg.sv
package tlp_pkg;
  localparam int unsigned TLP_WORD_W = 24;
  localparam int unsigned TLP_SEL_W  = 2;
  localparam int unsigned TLP_SYNC_STAGES = 2;
endpackage

// File: rtl/tlp_sync.sv
module tlp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tlp_rise_det.sv
module tlp_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/tlp_shifter.sv
module tlp_shifter #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (shift_i) word_q <= {word_q[WORD_W-2:0], bit_i};
  end

  assign word_o = word_q;

  AST_SHIFT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])) && (word_o[0] == $past(bit_i))); // R1
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(word_o)); // R2
endmodule

// File: rtl/tlp_regbank.sv
module tlp_regbank #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned NREG  = 1 << SEL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [WORD_W-1:0]      word_i,
  output logic [NREG*WORD_W-1:0] regs_o
);
  logic [NREG-1:0]   wr_vec;
  logic [WORD_W-1:0] bank_q [NREG];

  genvar k;
  generate
    for (k = 0; k < NREG; k++) begin : g_reg
      assign wr_vec[k] = load_i && (word_i[SEL_W-1:0] == SEL_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q[k] <= '0;
        else if (wr_vec[k]) bank_q[k] <= word_i;
      end

      assign regs_o[k*WORD_W +: WORD_W] = bank_q[k];

      AST_WRITE_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vec[k] |=> regs_o[k*WORD_W +: WORD_W] == $past(word_i)); // R4
      AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vec[k] |=> $stable(regs_o[k*WORD_W +: WORD_W])); // R5
    end
  endgenerate

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)); // R3
  AST_LOAD_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> $countones(wr_vec) == 1); // R3
endmodule

// File: rtl/triwire_load_port.sv
module triwire_load_port #(
  parameter int unsigned WORD_W = tlp_pkg::TLP_WORD_W,
  parameter int unsigned SEL_W  = tlp_pkg::TLP_SEL_W,
  parameter int unsigned STAGES = tlp_pkg::TLP_SYNC_STAGES,
  localparam int unsigned NREG  = 1 << SEL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  input  logic                   sload_i,
  output logic [NREG*WORD_W-1:0] regs_o
);
  logic [2:0]        pins_s;
  logic              sclk_rise;
  logic              load_stb;
  logic [WORD_W-1:0] shift_word;

  tlp_sync #(.W(3), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sload_i, sdata_i, sclk_i}),
    .q_o   (pins_s)
  );

  tlp_rise_det u_sclk_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (pins_s[0]),
    .rise_o  (sclk_rise)
  );

  tlp_rise_det u_load_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (pins_s[2]),
    .rise_o  (load_stb)
  );

  tlp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (sclk_rise),
    .bit_i   (pins_s[1]),
    .word_o  (shift_word)
  );

  tlp_regbank #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_stb),
    .word_i (shift_word),
    .regs_o (regs_o)
  );

  AST_LOAD_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> pins_s[2]); // R7
endmodule

// File: tb/triwire_load_port_tb.sv
module triwire_load_port_tb;
  localparam int W = 24;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [4*W-1:0] regs;
  logic [W-1:0] expv [4];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  triwire_load_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .sload_i(sload), .regs_o(regs)
  );

  function automatic logic [W-1:0] get_reg(input logic [4*W-1:0] r, input int k);
    return r[k*W +: W];
  endfunction

  function automatic int target_of(input logic [W-1:0] w);
    return int'(w[1:0]);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int k = 0; k < 4; k++) chk(req, get_reg(regs, k), expv[k]);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i];
      sclk = 1'b0;
      wait_neg(HALF);
      sclk = 1'b1;
      wait_neg(HALF);
    end
    sclk = 1'b0;
    wait_neg(HALF);
  endtask

  task automatic pulse_load();
    sload = 1'b1;
    wait_neg(4);
    sload = 1'b0;
    wait_neg(4);
  endtask

  initial begin
    logic [W-1:0] w;
    logic [W-1:0] held;
    logic [63:0] junk;
    int extra;
    void'($urandom(32'd20240611));
    wait_neg(3);
    // R6: cleared during reset
    for (int k = 0; k < 4; k++) begin expv[k] = '0; end
    chk_all("R6 reset");
    rst_n = 1'b1;
    wait_neg(2);

    // R3/R4/R1: each address directed
    for (int k = 0; k < 4; k++) begin
      w = {22'h2A5C3 ^ 22'(k * 22'h1111), 2'(k)};
      send_bits(64'(w), W);
      pulse_load();
      expv[k] = w;
      chk_all("R3 R4 R1 directed address");
    end

    // R8: latency of exactly three edges
    w = 24'hF0F0_F1;
    send_bits(64'(w), W);
    sload = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 two edges old", get_reg(regs, 1), expv[1]);
    @(negedge clk);
    expv[1] = w;
    chk("R8 third edge new", get_reg(regs, 1), expv[1]);
    wait_neg(3);
    // R7: held high, new bits do not load
    held = 24'h5A5A_5A;
    send_bits(64'(held), W);
    wait_neg(6);
    chk_all("R7 held strobe no reload");
    sload = 1'b0;
    wait_neg(4);
    chk_all("R7 falling edge no load");
    pulse_load();
    expv[2] = held;
    chk_all("R7 next rise loads");

    // R2: over-long word keeps only last 24 bits
    junk = {$urandom, $urandom};
    w = 24'hC3_77_13;
    send_bits(junk, 17);
    send_bits(64'(w), W);
    pulse_load();
    expv[3] = w;
    chk_all("R2 overlong word");

    // Random mix: R1 R3 R4 R5 R2
    for (int n = 0; n < 40; n++) begin
      w = W'($urandom);
      extra = int'($urandom % 4) == 0 ? int'($urandom % 10) + 1 : 0;
      if (extra > 0) send_bits({$urandom, $urandom}, extra);
      send_bits(64'(w), W);
      pulse_load();
      expv[target_of(w)] = w;
      chk_all("R5 R4 random load");
    end

    // R6: reset again clears everything
    rst_n = 1'b0;
    wait_neg(2);
    for (int k = 0; k < 4; k++) expv[k] = '0;
    chk_all("R6 reset mid run");
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done == 1);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule